// File: doc/BRIEF.md
# Chip-to-chip expansion bus port

This block links a host-side register interface to peripherals on a second chip over a narrow shared bus. The bus carries 8-bit words one after another, with a single-bit valid from the sender and a single-bit acknowledge from the receiver. The primary side holds a round-robin arbiter and the access engine. The secondary side decodes the word stream and presents a plain register strobe interface to its local peripherals. Both sides are built into one top so that the whole word exchange can be exercised. Pad drive and clock forwarding belong to the surrounding design.

An access starts with a pulse on `host_go` while the engine is idle. The engine then requests the bus and waits for its grant. It sends one command word, the address words (most significant first) and one data word, and each word completes only in a cycle where valid and acknowledge are both high. For a read, the secondary side returns the data word. When no acknowledge arrives within a programmable number of cycles, the access is abandoned and reported as failed. Other bus masters share the bus through the `ext_req`/`ext_gnt` pins. A grant is kept until its owner drops its request.

Top module: `xbus_link`

## Requirements
- R1: After reset `host_busy`, `host_done`, `ext_gnt`, `sec_wr_stb` and `sec_rd_stb` are all low.
- R2: A write delivers one `sec_wr_stb` pulse. In that cycle `sec_func`, `sec_addr` and `sec_wdata` equal the host's function, address and data. The command word is {write flag in bit 7, zeros, function in the low bits}, and the address words are sent high byte first.
- R3: A read returns on `host_rdata` the value that `sec_rdata` had when the data word was acknowledged. It pulses `sec_rd_stb` once, leaves `sec_wr_stb` low and ends with `host_err` low.
- R4: A word completes only in a cycle with valid and acknowledge both high. The sender holds the word unchanged while valid is high and acknowledge is low, and acknowledge stays high for one cycle at a time.
- R5: At most one grant is active at a time, and the primary engine raises valid only while it holds the grant.
- R6: A grant stays with its owner for as long as the owner keeps its request high. While an external master holds the bus, a host access stays pending and no secondary strobe occurs.
- R7: Arbitration is round robin. When an external owner releases the bus, a waiting host access is granted and completes.
- R8: If valid stays high without acknowledge for `cfg_timeout` consecutive cycles (`cfg_timeout` nonzero), the access ends with `host_done` and `host_err` high and no secondary strobe. The next access then completes normally.
- R9: A `host_go` pulse while `host_busy` is high is ignored. Only the first access reaches the secondary side.
- R10: The secondary side acknowledges the data word only while `sec_ready` is high. A late `sec_ready`, arriving within the timeout, still completes the access with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| host_go | input | 1 | Start an access (taken only when idle) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_func | input | FW | Target function on the secondary chip |
| host_addr | input | AW | Register address |
| host_wdata | input | 8 | Write data |
| cfg_timeout | input | TW | Acknowledge timeout in cycles, 0 disables |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle pulse at the end of an access |
| host_err | output | 1 | Last access timed out (valid from done until next go) |
| host_rdata | output | 8 | Read data of the last read |
| ext_req | input | NREQ-1 | Bus requests of other masters |
| ext_gnt | output | NREQ-1 | Bus grants to other masters |
| sec_wr_stb | output | 1 | Secondary write strobe |
| sec_rd_stb | output | 1 | Secondary read strobe |
| sec_func | output | FW | Decoded function |
| sec_addr | output | AW | Decoded address |
| sec_wdata | output | 8 | Decoded write data |
| sec_rdata | input | 8 | Read data from secondary peripherals |
| sec_ready | input | 1 | Secondary peripheral ready for the data word |

## Verification
If the word counters on the two sides fall out of step, the error shows at the secondary strobe within one access. It appears as a wrong function, a wrong address or a missing pulse, roughly ten cycles after `host_go`. A stuck arbiter or a grant that is released too early shows as `host_busy` that never falls, or as a strobe that fires while an external master holds the bus. A timeout counter that misbehaves shows as a false `host_err` on a slow but legal data word. It can also show as an engine that hangs, or that fails the next access after an abort.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    P_IDLE,
    P_REQ,
    P_WORD,
    P_REL
  } pri_st_t;

  // command word: write flag on top, function in the low bits
  function automatic logic [7:0] make_cmd(input logic we, input logic [6:0] fn);
    return {we, fn};
  endfunction

endpackage

// File: rtl/xbus_arb.sv
module xbus_arb #(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [IW-1:0] last;
  logic [IW-1:0] pick_idx;
  logic          any;

  always_comb begin
    int cand;
    any      = 1'b0;
    pick_idx = last;
    for (int k = 1; k <= NREQ; k++) begin
      cand = (int'(last) + k) % NREQ;
      if (!any && req[cand]) begin
        any      = 1'b1;
        pick_idx = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt  <= '0;
      last <= IW'(NREQ - 1);
    end else if (|gnt) begin
      if (!(|(gnt & req))) gnt <= '0;
    end else if (any) begin
      gnt  <= NREQ'(1) << pick_idx;
      last <= pick_idx;
    end
  end

endmodule

// File: rtl/xbus_pri.sv
module xbus_pri
  import xbus_pkg::*;
#(
  parameter int FW = 2,
  parameter int AW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we,
  input  logic [FW-1:0] func,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [TW-1:0] cfg_timeout,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    rdata,
  output logic          req,
  input  logic          gnt,
  output logic          val,
  output logic [7:0]    ad,
  input  logic          ack,
  input  logic [7:0]    ad_in
);
  localparam int AWORDS = AW / 8;
  localparam int NWORDS = AWORDS + 2;
  localparam int IXW    = $clog2(NWORDS);

  pri_st_t       st;
  logic [IXW-1:0] idx;
  logic          we_q;
  logic [FW-1:0] func_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q;
  logic [TW-1:0] tcnt;
  logic [7:0]    word_sel [NWORDS];

  always_comb begin
    word_sel[0] = make_cmd(we_q, 7'(func_q));
    for (int a = 0; a < AWORDS; a++)
      word_sel[1+a] = addr_q[AW-1-8*a -: 8];
    word_sel[NWORDS-1] = we_q ? wdata_q : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= P_IDLE;
      idx     <= '0;
      we_q    <= 1'b0;
      func_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      tcnt    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
      req     <= 1'b0;
      val     <= 1'b0;
      ad      <= '0;
    end else begin
      case (st)
        P_IDLE: begin
          done <= 1'b0;
          if (go) begin
            we_q    <= we;
            func_q  <= func;
            addr_q  <= addr;
            wdata_q <= wdata;
            busy    <= 1'b1;
            err     <= 1'b0;
            req     <= 1'b1;
            st      <= P_REQ;
          end
        end
        P_REQ: begin
          if (gnt) begin
            val  <= 1'b1;
            ad   <= word_sel[0];
            idx  <= '0;
            tcnt <= '0;
            st   <= P_WORD;
          end
        end
        P_WORD: begin
          if (ack) begin
            tcnt <= '0;
            if (idx == IXW'(NWORDS - 1)) begin
              val <= 1'b0;
              req <= 1'b0;
              if (!we_q) rdata <= ad_in;
              st  <= P_REL;
            end else begin
              idx <= idx + 1'b1;
              ad  <= word_sel[int'(idx) + 1];
            end
          end else if (cfg_timeout != '0 && tcnt == cfg_timeout - TW'(1)) begin
            val <= 1'b0;
            req <= 1'b0;
            err <= 1'b1;
            st  <= P_REL;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          if (!gnt) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= P_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/xbus_sec.sv
module xbus_sec #(
  parameter int FW = 2,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          owner_on,
  input  logic          val,
  input  logic [7:0]    ad,
  output logic          ack,
  output logic [7:0]    ad_out,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic [FW-1:0] func,
  output logic [AW-1:0] addr,
  output logic [7:0]    wdata,
  input  logic [7:0]    rdata,
  input  logic          ready
);
  localparam int NWORDS = AW / 8 + 2;
  localparam int IXW    = $clog2(NWORDS);
  localparam logic [IXW-1:0] LAST = IXW'(NWORDS - 1);

  logic [IXW-1:0] idx;
  logic           we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      we_q   <= 1'b0;
      ack    <= 1'b0;
      ad_out <= '0;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      func   <= '0;
      addr   <= '0;
      wdata  <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (!owner_on) begin
        idx <= '0;
        ack <= 1'b0;
      end else if (val && ack) begin
        ack <= 1'b0;
        if (idx == '0) begin
          we_q <= ad[7];
          func <= ad[FW-1:0];
          idx  <= idx + 1'b1;
        end else if (idx == LAST) begin
          if (we_q) begin
            wdata  <= ad;
            wr_stb <= 1'b1;
          end
          idx <= '0;
        end else begin
          addr <= {addr[AW-9:0], ad};
          idx  <= idx + 1'b1;
        end
      end else if (val) begin
        if (idx != LAST || ready) begin
          ack <= 1'b1;
          if (idx == LAST && !we_q) begin
            ad_out <= rdata;
            rd_stb <= 1'b1;
          end
        end
      end else begin
        ack <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xbus_link.sv
module xbus_link #(
  parameter int FW   = 2,
  parameter int AW   = 16,
  parameter int TW   = 8,
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_go,
  input  logic            host_we,
  input  logic [FW-1:0]   host_func,
  input  logic [AW-1:0]   host_addr,
  input  logic [7:0]      host_wdata,
  input  logic [TW-1:0]   cfg_timeout,
  output logic            host_busy,
  output logic            host_done,
  output logic            host_err,
  output logic [7:0]      host_rdata,
  input  logic [NREQ-2:0] ext_req,
  output logic [NREQ-2:0] ext_gnt,
  output logic            sec_wr_stb,
  output logic            sec_rd_stb,
  output logic [FW-1:0]   sec_func,
  output logic [AW-1:0]   sec_addr,
  output logic [7:0]      sec_wdata,
  input  logic [7:0]      sec_rdata,
  input  logic            sec_ready
);
  logic            m_req;
  logic            m_val;
  logic [7:0]      m_ad;
  logic            s_ack;
  logic [7:0]      s_ad;
  logic [NREQ-1:0] req_vec;
  logic [NREQ-1:0] gnt;

  assign req_vec = {ext_req, m_req};
  assign ext_gnt = gnt[NREQ-1:1];

  xbus_arb #(.NREQ(NREQ)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (req_vec),
    .gnt (gnt)
  );

  xbus_pri #(.FW(FW), .AW(AW), .TW(TW)) u_pri (
    .clk         (clk),
    .rst         (rst),
    .go          (host_go),
    .we          (host_we),
    .func        (host_func),
    .addr        (host_addr),
    .wdata       (host_wdata),
    .cfg_timeout (cfg_timeout),
    .busy        (host_busy),
    .done        (host_done),
    .err         (host_err),
    .rdata       (host_rdata),
    .req         (m_req),
    .gnt         (gnt[0]),
    .val         (m_val),
    .ad          (m_ad),
    .ack         (s_ack),
    .ad_in       (s_ad)
  );

  xbus_sec #(.FW(FW), .AW(AW)) u_sec (
    .clk      (clk),
    .rst      (rst),
    .owner_on (gnt[0]),
    .val      (m_val),
    .ad       (m_ad),
    .ack      (s_ack),
    .ad_out   (s_ad),
    .wr_stb   (sec_wr_stb),
    .rd_stb   (sec_rd_stb),
    .func     (sec_func),
    .addr     (sec_addr),
    .wdata    (sec_wdata),
    .rdata    (sec_rdata),
    .ready    (sec_ready)
  );

endmodule

// File: rtl/xbus_link_chk.sv
module xbus_link_chk #(
  parameter int NREQ = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req,
  input logic [NREQ-1:0] gnt,
  input logic            m_val,
  input logic [7:0]      m_ad,
  input logic            s_ack
);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R5

  AST_VAL_OWNER: assert property (@(posedge clk) disable iff (rst)
    m_val |-> gnt[0]); // R5

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_val && !s_ack) |=> (!m_val || $stable(m_ad))); // R4

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    s_ack |=> !s_ack); // R4

  AST_GRANT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|(gnt & req)) |=> (gnt == $past(gnt))); // R6

endmodule

bind xbus_link xbus_link_chk #(.NREQ(NREQ)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req   (req_vec),
  .gnt   (gnt),
  .m_val (m_val),
  .m_ad  (m_ad),
  .s_ack (s_ack)
);

// File: tb/test_xbus_link.sv
module test_xbus_link;
  localparam int FW = 2;
  localparam int AW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_go = 1'b0;
  logic          host_we = 1'b0;
  logic [FW-1:0] host_func = '0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_wdata = '0;
  logic [TW-1:0] cfg_timeout = 8'd16;
  logic          host_busy, host_done, host_err;
  logic [7:0]    host_rdata;
  logic [0:0]    ext_req = 1'b0;
  logic [0:0]    ext_gnt;
  logic          sec_wr_stb, sec_rd_stb;
  logic [FW-1:0] sec_func;
  logic [AW-1:0] sec_addr;
  logic [7:0]    sec_wdata;
  logic [7:0]    sec_rdata;
  logic          sec_ready = 1'b1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [FW-1:0] w_func;
  logic [AW-1:0] w_addr;
  logic [7:0]    w_data;

  always #2 clk = ~clk;

  xbus_link i_xbus_link (
    .clk(clk), .rst(rst), .host_go(host_go), .host_we(host_we),
    .host_func(host_func), .host_addr(host_addr), .host_wdata(host_wdata),
    .cfg_timeout(cfg_timeout), .host_busy(host_busy), .host_done(host_done),
    .host_err(host_err), .host_rdata(host_rdata), .ext_req(ext_req),
    .ext_gnt(ext_gnt), .sec_wr_stb(sec_wr_stb), .sec_rd_stb(sec_rd_stb),
    .sec_func(sec_func), .sec_addr(sec_addr), .sec_wdata(sec_wdata),
    .sec_rdata(sec_rdata), .sec_ready(sec_ready)
  );

  // peripheral model on the secondary side
  assign sec_rdata = sec_addr[7:0] ^ sec_addr[15:8] ^ {6'b0, sec_func};

  function automatic logic [7:0] exp_rd(input logic [AW-1:0] a, input logic [FW-1:0] f);
    return a[7:0] ^ a[15:8] ^ {6'b0, f};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sec_wr_stb) begin
      wr_cnt <= wr_cnt + 1;
      w_func <= sec_func;
      w_addr <= sec_addr;
      w_data <= sec_wdata;
    end
    if (sec_rd_stb) rd_cnt <= rd_cnt + 1;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic we, input logic [FW-1:0] f, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = we; host_func = f; host_addr = a; host_wdata = d; host_go = 1'b1;
    @(negedge clk);
    host_go = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (host_done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!host_busy && !host_done, "R1 busy/done", {host_busy, host_done}, 0);
    chk(ext_gnt == 1'b0, "R1 ext_gnt", ext_gnt, 0);
    chk(!sec_wr_stb && !sec_rd_stb, "R1 strobes", {sec_wr_stb, sec_rd_stb}, 0);
  endtask

  task automatic t_write(input logic [FW-1:0] f, input logic [AW-1:0] a, input logic [7:0] d);
    int n0; bit seen;
    n0 = wr_cnt;
    start(1'b1, f, a, d);
    wait_done(seen);
    chk(seen, "R2 done", seen, 1);
    chk(wr_cnt == n0 + 1, "R2 one strobe", wr_cnt - n0, 1);
    chk(w_func == f, "R2 func", w_func, f);
    chk(w_addr == a, "R2 addr", w_addr, a);
    chk(w_data == d, "R2 data", w_data, d);
    chk(!host_err, "R2 no err", host_err, 0);
  endtask

  task automatic t_read(input logic [FW-1:0] f, input logic [AW-1:0] a);
    int w0, r0; bit seen;
    w0 = wr_cnt; r0 = rd_cnt;
    start(1'b0, f, a, 8'h00);
    wait_done(seen);
    chk(seen, "R3 done", seen, 1);
    chk(host_rdata == exp_rd(a, f), "R3 rdata", host_rdata, exp_rd(a, f));
    chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R3 strobes", {rd_cnt - r0, wr_cnt - w0}, {32'd1, 32'd0});
    chk(!host_err, "R3 no err", host_err, 0);
  endtask

  task automatic t_busy_ignore;
    int n0; bit seen;
    n0 = wr_cnt;
    start(1'b1, 2'd2, 16'h1234, 8'h5A);
    @(negedge clk);
    host_we = 1'b1; host_func = 2'd1; host_addr = 16'hFFFF; host_wdata = 8'hEE; host_go = 1'b1;
    @(negedge clk);
    host_go = 1'b0;
    wait_done(seen);
    repeat (20) @(negedge clk);
    chk(wr_cnt == n0 + 1, "R9 single write", wr_cnt - n0, 1);
    chk(w_addr == 16'h1234 && w_data == 8'h5A, "R9 first kept", {w_addr, w_data}, {16'h1234, 8'h5A});
    chk(!host_busy, "R9 idle after", host_busy, 0);
  endtask

  task automatic t_ext_hold;
    int n0; bit seen;
    n0 = wr_cnt;
    @(negedge clk); ext_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(ext_gnt == 1'b1, "R6 ext granted", ext_gnt, 1);
    start(1'b1, 2'd3, 16'hBEEF, 8'h77);
    repeat (30) @(negedge clk);
    chk(host_busy && wr_cnt == n0, "R6 host pending", {host_busy, wr_cnt - n0}, {1'b1, 32'd0});
    chk(ext_gnt == 1'b1, "R6 grant kept", ext_gnt, 1);
    ext_req = 1'b0;
    wait_done(seen);
    chk(seen && wr_cnt == n0 + 1, "R7 host served", wr_cnt - n0, 1);
    chk(w_addr == 16'hBEEF && w_data == 8'h77, "R7 data", {w_addr, w_data}, {16'hBEEF, 8'h77});
    chk(ext_gnt == 1'b0, "R7 ext released", ext_gnt, 0);
  endtask

  task automatic t_timeout;
    int n0; bit seen;
    n0 = wr_cnt;
    cfg_timeout = 8'd8;
    sec_ready = 1'b0;
    start(1'b1, 2'd1, 16'h0F0F, 8'h99);
    wait_done(seen);
    chk(seen, "R8 done", seen, 1);
    chk(host_err, "R8 err", host_err, 1);
    chk(wr_cnt == n0, "R8 no strobe", wr_cnt - n0, 0);
    sec_ready = 1'b1;
    t_read(2'd2, 16'h4321);
    chk(!host_err, "R8 recovered", host_err, 0);
  endtask

  task automatic t_slow_ready;
    bit seen;
    cfg_timeout = 8'd16;
    sec_ready = 1'b0;
    start(1'b0, 2'd1, 16'hC3A5, 8'h00);
    repeat (10) @(negedge clk);
    chk(host_busy, "R10 waits", host_busy, 1);
    sec_ready = 1'b1;
    wait_done(seen);
    chk(seen && !host_err, "R10 no err", host_err, 0);
    chk(host_rdata == exp_rd(16'hC3A5, 2'd1), "R10 rdata", host_rdata, exp_rd(16'hC3A5, 2'd1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write(2'd3, 16'hA55A, 8'h3C);
    t_write(2'd1, 16'h0102, 8'hFF);
    t_read(2'd0, 16'h8001);
    t_read(2'd3, 16'h00FF);
    t_busy_ignore();
    t_ext_hold();
    t_timeout();
    t_slow_ready();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule